// File: doc/BRIEF.md
# Framed SPI Register Bank Slave

This block is an SPI slave that gives a host read and write access to a bank of 128 byte-wide registers. The bus runs in mode 0: the host drives MOSI while SCLK is low, both sides sample on the rising SCLK edge, and an active-low chip select brackets each transfer. SCLK, chip select and MOSI come in through two-flop synchronisers and are oversampled by the system clock, so SCLK must be well below half the system clock rate. A transfer opens with a command byte, most significant bit first. One or three data bytes follow. Each data byte goes to the next register in turn, and during that byte MISO returns the register's old contents.

Writes never reach the bank while chip select is low. Each received write byte is parked with its address in a three-entry staging buffer. When chip select rises, the frame controller checks the number of SCLK rising edges it counted. If the count is exactly 16 or 32 and the command asked for a write, the whole buffer is applied to the bank in one system-clock cycle. Any other count throws the buffer away and raises `frame_err` for one cycle. Because nothing changes during a frame, every byte read back shows the bank as it stood when chip select fell.

The frame controller moves through four states. `ST_IDLE` waits for chip select to fall, and that edge (transition *open*) clears the staging buffer and leads to `ST_CMD`. `ST_CMD` collects the command byte, and its eighth rising edge (transition *decode*) leads to `ST_DATA`. From `ST_CMD` or `ST_DATA`, the rise of chip select (transition *close*) leads to `ST_CHECK`. `ST_CHECK` judges the length, commits or discards, and always returns to `ST_IDLE` after one cycle (transition *settle*).

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset every register reads 0x00, `spi_miso` is low and `frame_err` is low.
- R2: The first byte of a frame is the command, sent most significant bit first. Bit 7 set to 1 means write and 0 means read. Bits 6..0 give the start address. MOSI is sampled on rising SCLK edges.
- R3: `spi_miso` is 0 for all eight bits of the command byte, and also whenever chip select is high.
- R4: The first data byte goes to the start address. Data bytes two and three go to the start address plus 1 and plus 2.
- R5: During each data byte, `spi_miso` shifts out the target register's previous contents, most significant bit first.
- R6: Every byte read back in a frame shows the bank as it stood when chip select fell, even for registers written earlier in the same frame.
- R7: Staged writes take effect only when chip select rises after exactly 16 or exactly 32 SCLK rising edges. Any other count leaves every register unchanged.
- R8: The address wraps from 0x7F to 0x00 within a frame.
- R9: A read command with a legal length writes nothing, whatever data bits arrive on MOSI.
- R10: `frame_err` pulses high for exactly one system clock after a frame of illegal length. It stays low after frames of 16 or 32 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, mode 0 (idle low) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Host-to-slave serial data |
| spi_miso | output | 1 | Slave-to-host serial data, 0 when not selected |
| frame_err | output | 1 | One-cycle pulse on a frame of illegal length |

## Verification
The assertions check on every cycle that MISO stays low while deselected and throughout the command byte. They check that the error pulse lasts one cycle and never coincides with a commit, and that a commit only happens with one or three staged entries. They also check that the staging buffer only fills under a write command. Whether the right bytes land at the right addresses, including the wrap past 0x7F, and whether readback shows pre-frame values, can only be shown by the bench's scenarios. The same holds for frames of 20, 24 or 40 edges leaving the bank untouched and for a legal-length read writing nothing. The bench reads the bank back over SPI in each of these cases.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_CHECK
    } frame_state_t;

endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
    parameter int unsigned      WIDTH   = 3,
    parameter int unsigned      STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 3,
    localparam int unsigned NREGS = 1 << ADDR_W,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stage_clr,
    input  logic              stage_push,
    input  logic [ADDR_W-1:0] stage_addr,
    input  logic [DATA_W-1:0] stage_data,
    input  logic              commit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  stage_cnt
);

    logic [DATA_W-1:0] bank   [NREGS];
    logic [ADDR_W-1:0] st_addr[DEPTH];
    logic [DATA_W-1:0] st_data[DEPTH];

    // staging buffer: fills in arrival order, extra bytes beyond DEPTH dropped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_cnt <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                st_addr[i] <= '0;
                st_data[i] <= '0;
            end
        end else if (stage_clr) begin
            stage_cnt <= '0;
        end else if (stage_push && (stage_cnt < CNT_W'(DEPTH))) begin
            st_addr[stage_cnt] <= stage_addr;
            st_data[stage_cnt] <= stage_data;
            stage_cnt          <= stage_cnt + 1'b1;
        end
    end

    // register bank: all valid staged entries applied in one cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREGS; r++) bank[r] <= '0;
        end else if (commit) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) < stage_cnt) bank[st_addr[i]] <= st_data[i];
            end
        end
    end

    assign rd_data = bank[rd_addr];

endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
    import spi_rb_pkg::*;
#(
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned DATA_W    = 8,
    localparam int unsigned SHORT_LEN = 2 * DATA_W,
    localparam int unsigned LONG_LEN  = 4 * DATA_W,
    localparam int unsigned CNT_W     = $clog2(LONG_LEN) + 1,
    localparam int unsigned BIT_W     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              stage_clr,
    output logic              stage_push,
    output logic [ADDR_W-1:0] stage_addr,
    output logic [DATA_W-1:0] stage_data,
    output logic              commit,
    output logic              frame_err,
    output logic              miso,
    output logic              cmd_wr,
    output frame_state_t      state
);

    frame_state_t      state_nx;
    logic              sclk_q, cs_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_sr, tx_sr, full_byte;
    logic [ADDR_W-1:0] ptr;
    logic              sclk_rise, cs_fall, cs_rise, active, byte_done, legal;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign cs_fall   = cs_q & ~cs_n_s;
    assign cs_rise   = ~cs_q & cs_n_s;
    assign active    = (state == ST_CMD) || (state == ST_DATA);
    assign full_byte = {rx_sr[DATA_W-2:0], mosi_s};
    assign byte_done = active && sclk_rise && !cs_rise
                       && (bit_cnt[BIT_W-1:0] == {BIT_W{1'b1}})
                       && (bit_cnt != {CNT_W{1'b1}});
    assign legal     = (bit_cnt == CNT_W'(SHORT_LEN)) || (bit_cnt == CNT_W'(LONG_LEN));
    assign rd_addr   = (state == ST_CMD) ? full_byte[ADDR_W-1:0] : ADDR_W'(ptr + 1'b1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cs_fall) state_nx = ST_CMD;
            ST_CMD:   if (cs_rise) state_nx = ST_CHECK;
                      else if (byte_done) state_nx = ST_DATA;
            ST_DATA:  if (cs_rise) state_nx = ST_CHECK;
            ST_CHECK: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // shift and count datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            cs_q    <= 1'b1;
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            ptr     <= '0;
            cmd_wr  <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_n_s;
            if (state == ST_IDLE && cs_fall) begin
                bit_cnt <= '0;
                tx_sr   <= '0;
            end else if (active && sclk_rise && !cs_rise) begin
                rx_sr <= full_byte;
                if (bit_cnt != {CNT_W{1'b1}}) bit_cnt <= bit_cnt + 1'b1;
                if (byte_done) begin
                    tx_sr <= rd_data;
                    ptr   <= rd_addr;
                    if (state == ST_CMD) cmd_wr <= full_byte[DATA_W-1];
                end else begin
                    tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    // outputs
    always_comb begin
        stage_clr  = 1'b0;
        stage_push = 1'b0;
        commit     = 1'b0;
        frame_err  = 1'b0;
        miso       = 1'b0;
        stage_addr = ptr;
        stage_data = full_byte;
        unique case (state)
            ST_IDLE:  stage_clr  = cs_fall;
            ST_CMD:   miso       = tx_sr[DATA_W-1];
            ST_DATA: begin
                miso       = tx_sr[DATA_W-1];
                stage_push = byte_done && cmd_wr;
            end
            ST_CHECK: begin
                commit    = legal && cmd_wr;
                frame_err = !legal;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
    import spi_rb_pkg::*;
#(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned STAGE_DEPTH = 3,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned STG_CNT_W  = $clog2(STAGE_DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic frame_err
);

    logic                 sclk_s, cs_n_s, mosi_s;
    logic [ADDR_W-1:0]    rd_addr, stage_addr;
    logic [DATA_W-1:0]    rd_data, stage_data;
    logic                 stage_clr, stage_push, commit, cmd_wr;
    logic [STG_CNT_W-1:0] stage_cnt;
    frame_state_t         state;

    spi_rb_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sclk, spi_cs_n, spi_mosi}),
        .q     ({sclk_s, cs_n_s, mosi_s})
    );

    spi_rb_frame #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sclk_s),
        .cs_n_s     (cs_n_s),
        .mosi_s     (mosi_s),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .stage_clr  (stage_clr),
        .stage_push (stage_push),
        .stage_addr (stage_addr),
        .stage_data (stage_data),
        .commit     (commit),
        .frame_err  (frame_err),
        .miso       (spi_miso),
        .cmd_wr     (cmd_wr),
        .state      (state)
    );

    spi_rb_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (STAGE_DEPTH)
    ) i_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .stage_clr  (stage_clr),
        .stage_push (stage_push),
        .stage_addr (stage_addr),
        .stage_data (stage_data),
        .commit     (commit),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .stage_cnt  (stage_cnt)
    );

endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker
    import spi_rb_pkg::*;
#(
    parameter int unsigned CNT_W = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         spi_cs_n,
    input logic         spi_miso,
    input logic         frame_err,
    input logic         commit,
    input logic         cmd_wr,
    input logic [CNT_W-1:0] stage_cnt,
    input frame_state_t state
);

    // R3: deselected for several cycles means MISO is quiet
    a_r3_miso_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso);

    // R3: command byte shifts out zeros
    a_r3_miso_zero_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD) |-> !spi_miso);

    // R10: error flag is a single-cycle pulse
    a_r10_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // R7: an illegal frame never commits
    a_r7_err_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !commit);

    // R7: a commit carries one byte (16 edges) or three bytes (32 edges)
    a_r7_commit_sizes: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (stage_cnt == CNT_W'(1) || stage_cnt == CNT_W'(3)));

    // R9: staging only fills under a write command
    a_r9_stage_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_cnt != '0) |-> cmd_wr);

endmodule

bind spi_regbank_slave spi_rb_checker #(.CNT_W(STG_CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_miso  (spi_miso),
    .frame_err (frame_err),
    .commit    (commit),
    .cmd_wr    (cmd_wr),
    .stage_cnt (stage_cnt),
    .state     (state)
);

// File: tb/test_spi_regbank_slave.sv
module test_spi_regbank_slave;

    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso;
    logic frame_err;

    int n_checks = 0;
    int n_fails  = 0;
    int err_pulses = 0;

    always #2 clk = ~clk;

    always @(posedge clk) if (frame_err) err_pulses++;

    spi_regbank_slave i_spi_regbank_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .frame_err (frame_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // out_bits is MSB-aligned: bit 31 goes first; in_bits holds nbits captured MISO bits
    task automatic xfer(input int nbits, input logic [31:0] out_bits, output logic [31:0] in_bits);
        in_bits = '0;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            spi_mosi = out_bits[31-b];
            repeat (HALF) @(negedge clk);
            in_bits = {in_bits[30:0], spi_miso};
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic rd1(input logic [6:0] a, output logic [7:0] v);
        logic [31:0] r;
        xfer(16, {1'b0, a, 8'h00, 16'h0}, r);
        v = r[7:0];
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 miso after reset", 32'(spi_miso), 32'h0);
        chk("R1 frame_err after reset", 32'(frame_err), 32'h0);
        rd1(7'h10, v);
        chk("R1 reg 0x10 after reset", 32'(v), 32'h00);
        rd1(7'h7F, v);
        chk("R1 reg 0x7F after reset", 32'(v), 32'h00);
    endtask

    task automatic t_short_write();
        logic [31:0] r;
        logic [7:0] v;
        int e0 = err_pulses;
        xfer(16, {8'h85, 8'hA5, 16'h0}, r);
        chk("R3 cmd byte zeros / R5 old value", r & 32'hFFFF, 32'h0000);
        chk("R10 no error on 16", 32'(err_pulses - e0), 32'h0);
        rd1(7'h05, v);
        chk("R2 R7 write 0x05 16 edges", 32'(v), 32'hA5);
        xfer(16, {8'h85, 8'h5A, 16'h0}, r);
        chk("R5 old value shifted out", r & 32'hFFFF, 32'h00A5);
        rd1(7'h05, v);
        chk("R7 rewrite 0x05", 32'(v), 32'h5A);
    endtask

    task automatic t_long_write();
        logic [31:0] r;
        int e0 = err_pulses;
        xfer(32, {8'hA0, 8'h11, 8'h22, 8'h33}, r);
        chk("R10 no error on 32", 32'(err_pulses - e0), 32'h0);
        xfer(32, {8'hA0, 8'hAA, 8'hBB, 8'hCC}, r);
        chk("R4 R5 R6 pre-frame values 0x20..0x22", r, 32'h00112233);
        xfer(32, {8'h20, 24'h0}, r);
        chk("R4 burst landed 0x20..0x22", r, 32'h00AABBCC);
    endtask

    task automatic t_own_readback();
        logic [31:0] r;
        // write 0x30..0x32 where 0x31 written then read in same frame via wrap-free burst
        xfer(32, {8'hB0, 8'h01, 8'h02, 8'h03}, r);
        xfer(32, {8'hB1, 8'hF1, 8'hF2, 8'hF3}, r);
        chk("R6 readback ignores same-frame writes", r, 32'h00020300);
    endtask

    task automatic t_wrap();
        logic [31:0] r;
        logic [7:0] v;
        xfer(32, {8'hFE, 8'h44, 8'h55, 8'h66}, r);
        rd1(7'h7E, v);
        chk("R8 0x7E", 32'(v), 32'h44);
        rd1(7'h7F, v);
        chk("R8 0x7F", 32'(v), 32'h55);
        rd1(7'h00, v);
        chk("R8 wrapped to 0x00", 32'(v), 32'h66);
    endtask

    task automatic t_bad_len(input int n);
        logic [31:0] r;
        logic [7:0] v;
        int e0 = err_pulses;
        xfer(n, {8'h85, 8'hEE, 8'hEE, 8'hEE}, r);
        chk("R10 one error pulse on bad length", 32'(err_pulses - e0), 32'h1);
        rd1(7'h05, v);
        chk("R7 bad length leaves 0x05", 32'(v), 32'h5A);
        rd1(7'h06, v);
        chk("R7 bad length leaves 0x06", 32'(v), 32'h00);
    endtask

    task automatic t_read_cmd();
        logic [31:0] r;
        logic [7:0] v;
        xfer(16, {8'h05, 8'hFF, 16'h0}, r);
        chk("R9 read shows value", r & 32'hFFFF, 32'h005A);
        rd1(7'h05, v);
        chk("R9 read cmd wrote nothing 16", 32'(v), 32'h5A);
        xfer(32, {8'h20, 8'h99, 8'h98, 8'h97}, r);
        xfer(32, {8'h20, 24'h0}, r);
        chk("R9 read cmd wrote nothing 32", r, 32'h00AABBCC);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_short_write();
        t_long_write();
        t_own_readback();
        t_wrap();
        t_bad_len(24);
        t_bad_len(20);
        t_bad_len(40);
        t_bad_len(8);
        t_read_cmd();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule